// File: doc/BRIEF.md
# Battery-backed key store controller

This block is a 32-bit memory-mapped register slave that guards a secret key held in nine 32-bit words. Words 0 to 7 form the key and word 8 is an extra user word. Software can change the key only after unlocking a programming mode with a fixed magic value. Key words can never be read back. A self-clearing command wipes the key. Word 8 can be frozen by a sticky lock bit.

While programming mode is active, software can ask the block to check the stored key. It writes an expected CRC value, and the block computes a CRC-32C over the key serially, one bit per clock. It then reports whether the check has finished and whether the values matched. Accesses to unmapped offsets can raise a maskable slave-error interrupt.

There are two resets. The power-on reset clears everything. The ordinary reset restores the control state but keeps the key words, the programming mode and the lock. Both resets are active low and asynchronous, and their release is expected to be synchronous to `clk`. Only full 32-bit word accesses exist. `rdata` is combinational from `addr`.

Top module: `keystore_ctrl`

## Requirements
- R1: A write of exactly 0x757BDF0D to offset 0x08 sets status bit 0 (programming mode) at offset 0x00. Any other value leaves it unchanged. Only the power-on reset clears it.
- R2: Writes to key words 0 to 7 (offsets 0x10 to 0x2C) are dropped unless programming mode is set. Reads of these offsets and of the CRC register at 0x0C always return 0.
- R3: Word 8 (offset 0x30) takes a write only while programming mode is set and the lock is clear. It reads back its value when the parameter W8_WO is 0 and reads 0 when W8_WO is 1.
- R4: The lock (offset 0x4C, bit 0) can only be set by writing a 1 and is cleared only by the power-on reset. It never becomes set when W8_WO is 1.
- R5: Writing 1 to bit 0 of offset 0x04 clears key words 0 to 7, and also word 8 when W8_WO is 1. It sets status bit 4 (zeroized). Offset 0x04 always reads 0.
- R6: An accepted write of a nonzero value to a key word clears status bit 4. A write of zero leaves the bit unchanged. For word 8 the bit is cleared only when W8_WO is 1.
- R7: A write to 0x0C while programming mode is set and no check is running starts a check. The check first clears status bits 8 (done) and 9 (pass). Exactly (CRC_ZPAD+8)*32 clock edges after the write edge it sets bit 8, and it sets bit 9 if the written value equals a CRC-32C computed over CRC_ZPAD zero words followed by key words 0 to 7. Each word is taken as its little-endian bytes. The CRC uses the reflected polynomial 0x82F63B78, an all-ones initial value and a final inversion. Outside programming mode the write does nothing.
- R8: Writes to 0x0C while a check is running are ignored, up to and including the edge on which the check completes.
- R9: Bit 0 of the interrupt status register at 0x38 is cleared by writing 1. The mask at 0x3C is read-only and resets to 1. Writing 1 to 0x40 clears the mask bit and writing 1 to 0x44 sets it; both offsets read 0. `irq` equals the status bit AND NOT the mask bit.
- R10: Unmapped offsets read 0. These are 0x48, offsets of 0x50 and above, and offsets that are not word-aligned. When bit 0 of 0x34 is set, any read or write to an unmapped offset sets interrupt status bit 0, and writes to such offsets change no key word.
- R11: The ordinary reset restores status bits 4, 8 and 9, the slave-error enable, the interrupt status (to 0) and the mask (to 1). It keeps the key words, programming mode and the lock. The power-on reset returns every register and key word to 0, with the mask at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| rst_n | input | 1 | Ordinary reset, active low, keeps key, mode and lock |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe (used for slave-error detection) |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Slave-error interrupt, status and not masked |

## Verification
The serial CRC engine's final step and a new write to the CRC register can fall in the same cycle. The bench starts a check with a correct expected value and waits until one edge before completion. At that point it confirms through the ports that the done bit is still 0. It then writes a wrong value so that the write lands on the completing edge. The status must show done and pass from the first check, which proves the late write was dropped. Two instances share the same stimulus, one with word 8 readable and one with it write-only, so that zeroize, lock and zeroized-flag behaviour is judged for both variants in the same cycles.

// File: rtl/keystore_pkg.sv
package keystore_pkg;
  localparam int DW   = 32;
  localparam int NKEY = 8;

  localparam logic [DW-1:0] PGM_KEY  = 32'h757B_DF0D;
  localparam logic [DW-1:0] CRC_POLY = 32'h82F6_3B78;

  // word indices (byte offset / 4)
  localparam int OFS_STAT = 0;
  localparam int OFS_CTRL = 1;
  localparam int OFS_PGM  = 2;
  localparam int OFS_CRC  = 3;
  localparam int OFS_KEY0 = 4;
  localparam int OFS_SLV  = 13;
  localparam int OFS_ISR  = 14;
  localparam int OFS_IMR  = 15;
  localparam int OFS_IER  = 16;
  localparam int OFS_IDR  = 17;
  localparam int OFS_LOCK = 19;

  // status bit positions
  localparam int ST_PGM  = 0;
  localparam int ST_ZERO = 4;
  localparam int ST_DONE = 8;
  localparam int ST_PASS = 9;

  typedef struct packed {
    logic stat;
    logic ctrl;
    logic pgm;
    logic crc;
    logic key;
    logic slv;
    logic isr;
    logic imr;
    logic ier;
    logic idr;
    logic lock;
    logic unm;
  } ks_sel_t;
endpackage

// File: rtl/ks_key_bank.sv
module ks_key_bank #(
  parameter int W8_WO = 0
) (
  input  logic                                       clk,
  input  logic                                       por_n,
  input  logic                                       wr_stb,
  input  logic [3:0]                                 kidx,
  input  logic [keystore_pkg::DW-1:0]                wdata,
  input  logic                                       pgm,
  input  logic                                       lock,
  input  logic                                       zeroize,
  output logic [keystore_pkg::NKEY*keystore_pkg::DW-1:0] key_flat,
  output logic [keystore_pkg::DW-1:0]                w8_val,
  output logic                                       nz_acc
);
  import keystore_pkg::*;

  logic [NKEY-1:0] acc_k;
  logic            acc_8;
  logic            w8_clr;

  for (genvar g = 0; g < NKEY; g++) begin : g_key
    logic [DW-1:0] kq, kd;
    logic          ken;
    always_comb begin
      acc_k[g] = wr_stb && (kidx == 4'(g)) && pgm;
      ken      = acc_k[g] || zeroize;
      kd       = zeroize ? '0 : wdata;
    end
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)   kq <= '0;
      else if (ken) kq <= kd;
    end
    assign key_flat[g*DW +: DW] = kq;
  end

  // word 8 variant: cleared by zeroize only when write-only
  if (W8_WO != 0) begin : g_w8_wo
    assign w8_clr = zeroize;
  end else begin : g_w8_rw
    assign w8_clr = 1'b0;
  end

  logic [DW-1:0] w8_q, w8_d;
  logic          w8_en;
  always_comb begin
    acc_8 = wr_stb && (kidx == 4'(NKEY)) && pgm && !lock;
    w8_en = acc_8 || w8_clr;
    w8_d  = w8_clr ? '0 : wdata;
  end
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     w8_q <= '0;
    else if (w8_en) w8_q <= w8_d;
  end
  assign w8_val = w8_q;

  assign nz_acc = (|wdata) && ((|acc_k) || (acc_8 && (W8_WO != 0)));
endmodule

// File: rtl/ks_crc_serial.sv
module ks_crc_serial #(
  parameter int ZPAD = 1
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           start,
  input  logic [keystore_pkg::DW-1:0]                    ref_val,
  input  logic [keystore_pkg::NKEY*keystore_pkg::DW-1:0] key_flat,
  output logic                                           busy,
  output logic                                           done,
  output logic                                           pass
);
  import keystore_pkg::*;

  localparam int ZBITS = ZPAD * DW;
  localparam int KBITS = NKEY * DW;
  localparam int TOTAL = ZBITS + KBITS;
  localparam int CNT_W = $clog2(TOTAL);
  localparam int KI_W  = $clog2(KBITS);

  logic             busy_q, busy_d, done_q, done_d, pass_q, pass_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, off;
  logic [DW-1:0]    crc_q, crc_d, ref_q, ref_d, crc_step;
  logic             in_bit, fb, last;

  always_comb begin
    off      = cnt_q - CNT_W'(ZBITS);
    in_bit   = (cnt_q >= CNT_W'(ZBITS)) ? key_flat[off[KI_W-1:0]] : 1'b0;
    fb       = crc_q[0] ^ in_bit;
    crc_step = {1'b0, crc_q[DW-1:1]} ^ (fb ? CRC_POLY : '0);
    last     = busy_q && (cnt_q == CNT_W'(TOTAL - 1));

    busy_d = busy_q;
    done_d = done_q;
    pass_d = pass_q;
    cnt_d  = cnt_q;
    crc_d  = crc_q;
    ref_d  = ref_q;
    if (start) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      pass_d = 1'b0;
      cnt_d  = '0;
      crc_d  = '1;
      ref_d  = ref_val;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      crc_d = crc_step;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        pass_d = (~crc_step == ref_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      cnt_q  <= '0;
      crc_q  <= '0;
      ref_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      pass_q <= pass_d;
      if (start || busy_q) begin
        cnt_q <= cnt_d;
        crc_q <= crc_d;
      end
      if (start) ref_q <= ref_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign pass = pass_q;
endmodule

// File: rtl/ks_irq_unit.sv
module ks_irq_unit #(
  parameter int NSRC = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            isr_wr,
  input  logic            ier_wr,
  input  logic            idr_wr,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] isr,
  output logic [NSRC-1:0] imr,
  output logic            irq
);
  logic [NSRC-1:0] isr_q, isr_d, imr_q, imr_d;

  always_comb begin
    isr_d = (isr_q & ~(isr_wr ? wbits : '0)) | evt;
    imr_d = imr_q;
    if (ier_wr)      imr_d = imr_q & ~wbits;
    else if (idr_wr) imr_d = imr_q | wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      imr_q <= '1;
    end else begin
      isr_q <= isr_d;
      imr_q <= imr_d;
    end
  end

  assign isr = isr_q;
  assign imr = imr_q;
  assign irq = |(isr_q & ~imr_q);
endmodule

// File: rtl/keystore_ctrl.sv
module keystore_ctrl #(
  parameter int ADDR_W   = 8,
  parameter int W8_WO    = 0,
  parameter int CRC_ZPAD = 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  import keystore_pkg::*;

  localparam int WI_W = ADDR_W - 2;

  logic soft_n;
  assign soft_n = por_n & rst_n;

  // ---------------- decode ----------------
  logic [31:0] wi;
  logic [3:0]  kidx;
  ks_sel_t     sel;

  always_comb begin
    wi   = 32'(addr[ADDR_W-1:2]);
    kidx = 4'(wi - 32'(OFS_KEY0));
    sel  = '0;
    if (addr[1:0] != 2'b00)                 sel.unm  = 1'b1;
    else if (wi == 32'(OFS_STAT))           sel.stat = 1'b1;
    else if (wi == 32'(OFS_CTRL))           sel.ctrl = 1'b1;
    else if (wi == 32'(OFS_PGM))            sel.pgm  = 1'b1;
    else if (wi == 32'(OFS_CRC))            sel.crc  = 1'b1;
    else if (wi >= 32'(OFS_KEY0) &&
             wi <= 32'(OFS_KEY0 + NKEY))    sel.key  = 1'b1;
    else if (wi == 32'(OFS_SLV))            sel.slv  = 1'b1;
    else if (wi == 32'(OFS_ISR))            sel.isr  = 1'b1;
    else if (wi == 32'(OFS_IMR))            sel.imr  = 1'b1;
    else if (wi == 32'(OFS_IER))            sel.ier  = 1'b1;
    else if (wi == 32'(OFS_IDR))            sel.idr  = 1'b1;
    else if (wi == 32'(OFS_LOCK))           sel.lock = 1'b1;
    else                                    sel.unm  = 1'b1;
  end

  // ---------------- control state ----------------
  logic pgm_q, pgm_d, lock_q, lock_d, zero_q, zero_d, slv_q, slv_d;
  logic zeroize, nz_acc, slv_evt, crc_start;
  logic crc_busy, crc_done, crc_pass;
  logic isr_q, imr_q;
  logic [NKEY*DW-1:0] key_flat;
  logic [DW-1:0]      w8_val;

  always_comb begin
    zeroize   = wr_en && sel.ctrl && wdata[0];
    crc_start = wr_en && sel.crc && pgm_q && !crc_busy;
    slv_evt   = (wr_en || rd_en) && sel.unm && slv_q;

    pgm_d  = pgm_q | (wr_en && sel.pgm && (wdata == PGM_KEY));
    lock_d = (W8_WO != 0) ? 1'b0 : (lock_q | (wr_en && sel.lock && wdata[0]));
    slv_d  = (wr_en && sel.slv) ? wdata[0] : slv_q;
    if (zeroize)     zero_d = 1'b1;
    else if (nz_acc) zero_d = 1'b0;
    else             zero_d = zero_q;
  end

  // power-on-only state
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pgm_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      pgm_q  <= pgm_d;
      lock_q <= lock_d;
    end
  end

  // state restored by either reset
  always_ff @(posedge clk or negedge soft_n) begin
    if (!soft_n) begin
      zero_q <= 1'b0;
      slv_q  <= 1'b0;
    end else begin
      zero_q <= zero_d;
      slv_q  <= slv_d;
    end
  end

  // ---------------- sub-blocks ----------------
  ks_key_bank #(.W8_WO(W8_WO)) u_bank (
    .clk      (clk),
    .por_n    (por_n),
    .wr_stb   (wr_en && sel.key),
    .kidx     (kidx),
    .wdata    (wdata),
    .pgm      (pgm_q),
    .lock     (lock_q),
    .zeroize  (zeroize),
    .key_flat (key_flat),
    .w8_val   (w8_val),
    .nz_acc   (nz_acc)
  );

  ks_crc_serial #(.ZPAD(CRC_ZPAD)) u_crc (
    .clk      (clk),
    .rst_n    (soft_n),
    .start    (crc_start),
    .ref_val  (wdata),
    .key_flat (key_flat),
    .busy     (crc_busy),
    .done     (crc_done),
    .pass     (crc_pass)
  );

  ks_irq_unit #(.NSRC(1)) u_irq (
    .clk    (clk),
    .rst_n  (soft_n),
    .evt    (slv_evt),
    .isr_wr (wr_en && sel.isr),
    .ier_wr (wr_en && sel.ier),
    .idr_wr (wr_en && sel.idr),
    .wbits  (wdata[0]),
    .isr    (isr_q),
    .imr    (imr_q),
    .irq    (irq)
  );

  // ---------------- read mux ----------------
  always_comb begin
    rdata = '0;
    if (sel.stat) begin
      rdata[ST_PGM]  = pgm_q;
      rdata[ST_ZERO] = zero_q;
      rdata[ST_DONE] = crc_done;
      rdata[ST_PASS] = crc_pass;
    end else if (sel.key && kidx == 4'(NKEY) && W8_WO == 0) begin
      rdata = w8_val;
    end else if (sel.slv) begin
      rdata[0] = slv_q;
    end else if (sel.isr) begin
      rdata[0] = isr_q;
    end else if (sel.imr) begin
      rdata[0] = imr_q;
    end else if (sel.lock) begin
      rdata[0] = lock_q;
    end
  end
endmodule

// File: rtl/ks_ctrl_chk.sv
module ks_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int W8_WO  = 0
) (
  input logic                clk,
  input logic                por_n,
  input logic                soft_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [31:0]         wdata,
  input logic [31:0]         rdata,
  input logic                pgm,
  input logic                lock,
  input logic                zeroed,
  input logic                crc_busy,
  input logic                crc_done,
  input logic [255:0]        key_flat
);
  logic key_lo_hit, keyrd_hit;
  assign key_lo_hit = (addr >= ADDR_W'(8'h10)) && (addr <= ADDR_W'(8'h2C)) && (addr[1:0] == 2'b00);
  assign keyrd_hit  = (addr >= ADDR_W'(8'h0C)) && (addr <= ADDR_W'(8'h2C)) && (addr[1:0] == 2'b00);

  // R1
  pgm_magic_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && addr == ADDR_W'(8'h08) && wdata == 32'h757B_DF0D) |=> pgm);
  // R1
  pgm_sticky_chk: assert property (@(posedge clk) disable iff (!por_n) !$fell(pgm));
  // R2
  key_guard_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && key_lo_hit && !pgm) |=> $stable(key_flat));
  // R2
  key_hidden_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rd_en && keyrd_hit) |-> (rdata == 32'h0));
  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n) !$fell(lock));
  // R4
  lock_wo_chk: assert property (@(posedge clk) disable iff (!por_n)
    (W8_WO == 0) || !lock);
  // R5
  zeroize_chk: assert property (@(posedge clk) disable iff (!soft_n)
    (wr_en && addr == ADDR_W'(8'h04) && wdata[0]) |=> (zeroed && key_flat == '0));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!soft_n)
    $rose(crc_done) |-> !crc_busy);
  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rd_en && addr == ADDR_W'(8'h48)) |-> (rdata == 32'h0));
endmodule

bind keystore_ctrl ks_ctrl_chk #(.ADDR_W(ADDR_W), .W8_WO(W8_WO)) u_chk (
  .clk      (clk),
  .por_n    (por_n),
  .soft_n   (soft_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .pgm      (pgm_q),
  .lock     (lock_q),
  .zeroed   (zero_q),
  .crc_busy (crc_busy),
  .crc_done (crc_done),
  .key_flat (key_flat)
);

// File: tb/keystore_ctrl_test.sv
module keystore_ctrl_test;
  localparam int          ZP    = 1;
  localparam int          TOTAL = (ZP + 8) * 32;
  localparam logic [31:0] MAGIC = 32'h757B_DF0D;
  localparam logic [31:0] POLY  = 32'h82F6_3B78;

  logic        clk = 1'b0;
  logic        por_n, rst_n, wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rd_a, rd_b;
  logic        irq_a, irq_b;

  always #4 clk = ~clk;

  keystore_ctrl #(.ADDR_W(8), .W8_WO(0), .CRC_ZPAD(ZP)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rd_a), .irq(irq_a));

  keystore_ctrl #(.ADDR_W(8), .W8_WO(1), .CRC_ZPAD(ZP)) uut_wo (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rd_b), .irq(irq_b));

  int          n_cmp = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;
  logic [31:0] kmodel [8];
  logic [31:0] good;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd2(input string req, input string what, input logic [7:0] a,
                     input logic [31:0] ea, input logic [31:0] eb);
    logic [31:0] va, vb;
    addr = a; rd_en = 1'b1;
    #1;
    va = rd_a; vb = rd_b;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, {what, " (rw)"}, va, ea);
    chk(req, {what, " (wo)"}, vb, eb);
  endtask

  task automatic irq_chk(input string req, input logic e);
    chk(req, "irq (rw)", {31'd0, irq_a}, {31'd0, e});
    chk(req, "irq (wo)", {31'd0, irq_b}, {31'd0, e});
  endtask

  // CRC-32C, byte-wise over little-endian bytes of zero pad words then key
  function automatic logic [31:0] exp_crc();
    logic [31:0] c, w;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < ZP + 8; i++) begin
      w = (i < ZP) ? 32'h0 : kmodel[i - ZP];
      for (int b = 0; b < 4; b++) begin
        c = c ^ {24'h0, w[8*b +: 8]};
        for (int s = 0; s < 8; s++) c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
      end
    end
    return ~c;
  endfunction

  task automatic crc_run(input logic [31:0] v);
    wr(8'h0C, v);
    repeat (TOTAL) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    for (int k = 0; k < 8; k++) kmodel[k] = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);

    // R11 / R9 / R10: sweep every word offset after power-on reset
    for (int a = 0; a < 64; a++) begin
      logic [31:0] e;
      e = (a == 15) ? 32'h1 : 32'h0;
      rd2("R11", $sformatf("por default @%02h", a * 4), 8'(a * 4), e, e);
    end
    irq_chk("R9", 1'b0);

    // R2 / R3: writes outside programming mode are dropped
    for (int k = 0; k < 8; k++) wr(8'(8'h10 + 4 * k), 32'hC0DE_0000 + k);
    wr(8'h30, 32'h0000_FEED);
    rd2("R3", "word8 without pgm", 8'h30, 32'h0, 32'h0);
    // R7: CRC write outside programming mode does nothing
    wr(8'h0C, 32'h0);
    repeat (TOTAL + 2) @(negedge clk);
    rd2("R7", "crc outside pgm", 8'h00, 32'h0, 32'h0);

    // R1: every single-bit corruption of the magic value is rejected
    for (int i = 0; i < 32; i++) begin
      wr(8'h08, MAGIC ^ (32'h1 << i));
      rd2("R1", $sformatf("near-magic bit %0d", i), 8'h00, 32'h0, 32'h0);
    end
    wr(8'h08, MAGIC);
    rd2("R1", "magic accepted", 8'h00, 32'h1, 32'h1);
    rd2("R1", "pgm reg reads 0", 8'h08, 32'h0, 32'h0);

    // R2 / R7: key still zero proves earlier writes were dropped
    crc_run(exp_crc());
    rd2("R2", "crc over dropped key", 8'h00, 32'h301, 32'h301);

    // R2 / R3: program key, all reads hidden
    for (int k = 0; k < 8; k++) begin
      kmodel[k] = {8'(k + 1), 24'h5A_3C00 + 24'(k * 7)};
      wr(8'(8'h10 + 4 * k), kmodel[k]);
    end
    for (int k = 0; k < 8; k++) rd2("R2", $sformatf("key%0d hidden", k), 8'(8'h10 + 4 * k), 32'h0, 32'h0);
    rd2("R2", "crc reg hidden", 8'h0C, 32'h0, 32'h0);
    wr(8'h30, 32'hA5A5_0001);
    rd2("R3", "word8 readback", 8'h30, 32'hA5A5_0001, 32'h0);

    // R7 / R8: completion edge collides with a new CRC write
    good = exp_crc();
    wr(8'h0C, good);
    repeat (TOTAL - 1) @(negedge clk);
    addr = 8'h00; #1;
    chk("R7", "done not yet set one edge early", rd_a, 32'h001);
    wr(8'h0C, ~good);
    rd2("R8", "late write ignored, pass kept", 8'h00, 32'h301, 32'h301);
    repeat (TOTAL + 2) @(negedge clk);
    rd2("R8", "no second check started", 8'h00, 32'h301, 32'h301);
    crc_run(~good);
    rd2("R7", "mismatch sets done only", 8'h00, 32'h101, 32'h101);
    crc_run(good);
    rd2("R7", "match sets done and pass", 8'h00, 32'h301, 32'h301);

    // R5: zeroize
    wr(8'h04, 32'h1);
    for (int k = 0; k < 8; k++) kmodel[k] = '0;
    rd2("R5", "zeroized flag set", 8'h00, 32'h311, 32'h311);
    rd2("R5", "ctrl self-clears", 8'h04, 32'h0, 32'h0);
    rd2("R5", "word8 kept when readable", 8'h30, 32'hA5A5_0001, 32'h0);

    // R6: zeroized flag cleared by nonzero accepted writes
    wr(8'h30, 32'h0000_0BAD);
    rd2("R6", "word8 nonzero write", 8'h00, 32'h311, 32'h301);
    wr(8'h14, 32'h0);
    rd2("R6", "zero write keeps flag", 8'h00, 32'h311, 32'h301);
    wr(8'h14, 32'h0000_0077);
    kmodel[1] = 32'h0000_0077;
    rd2("R6", "key nonzero write clears flag", 8'h00, 32'h301, 32'h301);
    crc_run(exp_crc());
    rd2("R5", "crc after zeroize", 8'h00, 32'h301, 32'h301);

    // R4 / R3: lock
    wr(8'h4C, 32'h1);
    rd2("R4", "lock set", 8'h4C, 32'h1, 32'h0);
    wr(8'h4C, 32'h0);
    rd2("R4", "lock sticky", 8'h4C, 32'h1, 32'h0);
    wr(8'h30, 32'h0000_1234);
    rd2("R3", "word8 frozen by lock", 8'h30, 32'h0000_0BAD, 32'h0);

    // R10 / R9: slave error interrupt
    rd2("R10", "unmapped reads 0", 8'h48, 32'h0, 32'h0);
    rd2("R10", "no error when disabled", 8'h38, 32'h0, 32'h0);
    wr(8'h34, 32'h1);
    rd2("R10", "enable reads back", 8'h34, 32'h1, 32'h1);
    rd2("R10", "unmapped read", 8'h48, 32'h0, 32'h0);
    rd2("R10", "error status set", 8'h38, 32'h1, 32'h1);
    irq_chk("R9", 1'b0);
    wr(8'h40, 32'h1);
    rd2("R9", "mask cleared", 8'h3C, 32'h0, 32'h0);
    irq_chk("R9", 1'b1);
    wr(8'h44, 32'h1);
    irq_chk("R9", 1'b0);
    rd2("R9", "idr reads 0", 8'h44, 32'h0, 32'h0);
    wr(8'h40, 32'h1);
    rd2("R9", "ier reads 0", 8'h40, 32'h0, 32'h0);
    wr(8'h38, 32'h0);
    irq_chk("R9", 1'b1);
    wr(8'h38, 32'h1);
    irq_chk("R9", 1'b0);
    wr(8'h11, 32'hFFFF_FFFF);
    irq_chk("R10", 1'b1);
    wr(8'h38, 32'h1);
    wr(8'h90, 32'h1);
    rd2("R10", "high offset error", 8'h38, 32'h1, 32'h1);
    crc_run(exp_crc());
    rd2("R10", "misaligned write left key", 8'h00, 32'h301, 32'h301);

    // R11: ordinary reset keeps key, mode and lock
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd2("R11", "status after reset", 8'h00, 32'h001, 32'h001);
    rd2("R11", "lock kept", 8'h4C, 32'h1, 32'h0);
    rd2("R11", "mask restored", 8'h3C, 32'h1, 32'h1);
    rd2("R11", "status irq cleared", 8'h38, 32'h0, 32'h0);
    rd2("R11", "slverr enable cleared", 8'h34, 32'h0, 32'h0);
    rd2("R11", "word8 kept", 8'h30, 32'h0000_0BAD, 32'h0);
    irq_chk("R11", 1'b0);
    crc_run(exp_crc());
    rd2("R11", "key survives reset", 8'h00, 32'h301, 32'h301);

    // R11: power-on reset clears everything
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    rd2("R11", "por status", 8'h00, 32'h0, 32'h0);
    rd2("R11", "por lock", 8'h4C, 32'h0, 32'h0);
    rd2("R11", "por word8", 8'h30, 32'h0, 32'h0);
    rd2("R11", "por mask", 8'h3C, 32'h1, 32'h1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule